// File: doc/BRIEF.md
# 8-bit ALU with Flag Generation

This block is the combinational arithmetic and logic unit of a small accumulator CPU. It takes two 8-bit operands, the current carry flag and a 3-bit operation code. In the same cycle it returns the 8-bit result, values for the zero, digit-carry and carry flags, and one update enable per flag. The status register outside the block uses each enable to decide whether to load the matching flag.

Add and subtract share one adder. A subtract adds the two's complement of the second operand, so carry and digit carry come out as inverted borrows. Rotates pass through the carry flag. The old carry enters at one end of the byte, and the bit that leaves at the other end becomes the new carry.

Top module: `alu8_flags`

## Requirements
- R1: Op code 0 (add) gives result = (a + b) mod 256, and carry_o is 1 exactly when a + b exceeds 255.
- R2: For add, dcarry_o is 1 exactly when a[3:0] + b[3:0] exceeds 15, which is the carry from bit 3 into bit 4.
- R3: Op code 1 (subtract) gives result = (a - b) mod 256, and carry_o is 1 exactly when no borrow occurs (a >= b unsigned).
- R4: For subtract, dcarry_o is 1 exactly when the low nibble takes no borrow (a[3:0] >= b[3:0]).
- R5: For every op code, zero_o is 1 exactly when result_o is 0.
- R6: Op codes 2, 3 and 4 give a AND b, a OR b and a XOR b respectively.
- R7: Op code 5 (rotate left through carry) gives result {a[6:0], carry_i}, and carry_o equals a[7].
- R8: Op code 6 (rotate right through carry) gives result {carry_i, a[7:1]}, and carry_o equals a[0].
- R9: The update enables {upd_z_o, upd_dc_o, upd_c_o} are 111 for add and subtract, 100 for op codes 2 to 4, 001 for op codes 5 and 6, and 000 for op code 7.
- R10: A dcarry_o or carry_o whose update enable is 0 reads 0. Op code 7 gives result 0.
- R11: Subtracting equal operands gives result 0 with zero_o, dcarry_o and carry_o all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 8 | First operand; source of rotates |
| b_i | input | 8 | Second operand |
| carry_i | input | 1 | Current carry flag |
| op_i | input | 3 | Operation code |
| result_o | output | 8 | Operation result |
| zero_o | output | 1 | Zero flag value |
| dcarry_o | output | 1 | Digit carry flag value |
| carry_o | output | 1 | Carry flag value |
| upd_z_o | output | 1 | Zero flag update enable |
| upd_dc_o | output | 1 | Digit carry update enable |
| upd_c_o | output | 1 | Carry flag update enable |

## Verification
Two flag events can land on the same operation. A carry out of bit 7 can occur together with a zero result. A carry-in can enter a rotate in the same operation as the carry-out leaves it. The bench forces the first case with 0x80 + 0x80, which must give result 0 with Z=1, C=1 and DC=0. It forces the second with rotates of 0x80 and 0x01 with carry_i set, where the expected value holds both the injected bit and the ejected carry. Each case is judged against expected values that the bench computes with integer arithmetic.

// File: rtl/alu8_flags.sv
module alu8_flags #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         carry_i,
  input  logic [2:0]   op_i,
  output logic [W-1:0] result_o,
  output logic         zero_o,
  output logic         dcarry_o,
  output logic         carry_o,
  output logic         upd_z_o,
  output logic         upd_dc_o,
  output logic         upd_c_o
);
  localparam int NIB = 4;
  localparam logic [2:0] OP_ADD = 3'd0, OP_SUB = 3'd1, OP_AND = 3'd2, OP_OR = 3'd3,
                         OP_XOR = 3'd4, OP_RLC = 3'd5, OP_RRC = 3'd6;

  logic         sub;
  logic [W-1:0] bop;
  logic [NIB:0] lo;
  logic [W:0]   sum;

  assign sub = (op_i == OP_SUB);
  assign bop = sub ? ~b_i : b_i;
  assign lo  = {1'b0, a_i[NIB-1:0]} + {1'b0, bop[NIB-1:0]} + {{NIB{1'b0}}, sub};
  assign sum = {1'b0, a_i} + {1'b0, bop} + {{W{1'b0}}, sub};

  always_comb begin
    result_o = '0;
    dcarry_o = 1'b0;
    carry_o  = 1'b0;
    {upd_z_o, upd_dc_o, upd_c_o} = 3'b000;
    case (op_i)
      OP_ADD, OP_SUB: begin
        result_o = sum[W-1:0];
        dcarry_o = lo[NIB];
        carry_o  = sum[W];
        {upd_z_o, upd_dc_o, upd_c_o} = 3'b111;
      end
      OP_AND: begin result_o = a_i & b_i; upd_z_o = 1'b1; end
      OP_OR:  begin result_o = a_i | b_i; upd_z_o = 1'b1; end
      OP_XOR: begin result_o = a_i ^ b_i; upd_z_o = 1'b1; end
      OP_RLC: begin
        result_o = {a_i[W-2:0], carry_i};
        carry_o  = a_i[W-1];
        upd_c_o  = 1'b1;
      end
      OP_RRC: begin
        result_o = {carry_i, a_i[W-1:1]};
        carry_o  = a_i[0];
        upd_c_o  = 1'b1;
      end
      default: ;
    endcase
  end

  assign zero_o = ~|result_o;

  always_comb begin
    p_add_carry_r1: assert (op_i != OP_ADD || carry_o == (a_i > ~b_i));
    p_add_dc_r2:    assert (op_i != OP_ADD || dcarry_o == (a_i[NIB-1:0] > ~b_i[NIB-1:0]));
    p_sub_carry_r3: assert (op_i != OP_SUB || carry_o == (a_i >= b_i));
    p_sub_dc_r4:    assert (op_i != OP_SUB || dcarry_o == (a_i[NIB-1:0] >= b_i[NIB-1:0]));
    p_zero_r5:      assert (zero_o == (result_o == '0));
    p_upd_r9:       assert ($countones({upd_z_o, upd_dc_o, upd_c_o}) != 2);
    p_gate_r10:     assert ((upd_c_o || !carry_o) && (upd_dc_o || !dcarry_o));
    p_eq_sub_r11:   assert (op_i != OP_SUB || a_i != b_i || (zero_o && carry_o && dcarry_o));
  end
endmodule

// File: tb/alu8_flags_tb.sv
module alu8_flags_tb;
  logic       clk = 1'b0;
  logic [7:0] a, b;
  logic       cin;
  logic [2:0] op;
  logic [7:0] res;
  logic       z, dc, c, uz, udc, uc;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  alu8_flags u_dut (
    .a_i(a), .b_i(b), .carry_i(cin), .op_i(op),
    .result_o(res), .zero_o(z), .dcarry_o(dc), .carry_o(c),
    .upd_z_o(uz), .upd_dc_o(udc), .upd_c_o(uc)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [2:0] o, input logic [7:0] x, input logic [7:0] y, input logic ci);
    @(negedge clk);
    op = o; a = x; b = y; cin = ci;
    #1;
  endtask

  task automatic t_add(input logic [7:0] x, input logic [7:0] y);
    int s;
    s = int'(x) + int'(y);
    apply(3'd0, x, y, 1'b0);
    chk("R1 add result", res, s % 256);
    chk("R1 add carry", c, int'(s > 255));
    chk("R2 add dcarry", dc, int'((x % 16) + (y % 16) > 15));
    chk("R5 add zero", z, int'(s % 256 == 0));
    chk("R9 add enables", {uz, udc, uc}, 7);
  endtask

  task automatic t_sub(input logic [7:0] x, input logic [7:0] y);
    int d;
    d = int'(x) - int'(y);
    apply(3'd1, x, y, 1'b1);
    chk("R3 sub result", res, (d + 256) % 256);
    chk("R3 sub carry", c, int'(x >= y));
    chk("R4 sub dcarry", dc, int'((x % 16) >= (y % 16)));
    chk("R5 sub zero", z, int'(d == 0));
    chk("R9 sub enables", {uz, udc, uc}, 7);
    if (x == y) chk("R11 equal sub flags", {z, dc, c}, 7);
  endtask

  task automatic t_logic(input logic [7:0] x, input logic [7:0] y);
    apply(3'd2, x, y, 1'b1);
    chk("R6 and", res, x & y);
    chk("R5 and zero", z, int'((x & y) == 0));
    chk("R9 logic enables", {uz, udc, uc}, 4);
    chk("R10 logic c/dc zero", {dc, c}, 0);
    apply(3'd3, x, y, 1'b0);
    chk("R6 or", res, x | y);
    apply(3'd4, x, y, 1'b1);
    chk("R6 xor", res, x ^ y);
    chk("R5 xor zero", z, int'((x ^ y) == 0));
  endtask

  task automatic t_rot(input logic [7:0] x, input logic ci);
    apply(3'd5, x, 8'h00, ci);
    chk("R7 rlc result", res, ((int'(x) * 2) % 256) + int'(ci));
    chk("R7 rlc carry", c, int'(x >= 128));
    chk("R9 rot enables", {uz, udc, uc}, 1);
    chk("R10 rot dc zero", dc, 0);
    chk("R5 rlc zero", z, int'(((int'(x) * 2) % 256) + int'(ci) == 0));
    apply(3'd6, x, 8'h00, ci);
    chk("R8 rrc result", res, int'(x) / 2 + (ci ? 128 : 0));
    chk("R8 rrc carry", c, int'(x) % 2);
  endtask

  task automatic t_op7();
    apply(3'd7, 8'hA5, 8'h5A, 1'b1);
    chk("R10 op7 result", res, 0);
    chk("R9 op7 enables", {uz, udc, uc}, 0);
    chk("R10 op7 flags", {dc, c}, 0);
    chk("R5 op7 zero", z, 1);
  endtask

  initial begin
    op = 3'd0; a = '0; b = '0; cin = 1'b0;
    #1;
    chk("R5 initial zero", z, 1);
    t_add(8'h12, 8'h34);
    t_add(8'h0F, 8'h01);
    t_add(8'hFF, 8'h01);
    t_add(8'h80, 8'h80);
    t_add(8'h7F, 8'h7F);
    t_sub(8'h50, 8'h20);
    t_sub(8'h20, 8'h50);
    t_sub(8'h10, 8'h01);
    t_sub(8'h3C, 8'h3C);
    t_sub(8'h00, 8'hFF);
    t_logic(8'hF0, 8'h0F);
    t_logic(8'hA5, 8'h3C);
    t_logic(8'h55, 8'h55);
    t_rot(8'h80, 1'b1);
    t_rot(8'h01, 1'b1);
    t_rot(8'h80, 1'b0);
    t_rot(8'h01, 1'b0);
    t_rot(8'h6B, 1'b0);
    t_op7();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired: got hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule